// File: doc/BRIEF.md
# Mixed-Decay PWM Chopping Controller

This block sequences the four gate enables of one H-bridge so that a stepper winding current stays near its setpoint. A free-running reference tick is divided into chopping periods. Each period opens with a Charge phase that drives current into the winding. When the peak comparator reports that the threshold is reached, the bridge reverses into Fast Decay. When the decay comparator reports that the current has dropped to the lower mixed-decay level, the bridge shorts the winding through both low-side switches (Slow Decay) until the next period begins.

The comparators, the current-setting DAC and the oscillator stay outside the block; they arrive as synchronous single-bit inputs. Each comparator is ignored for a programmable number of clock cycles after the phase that watches it begins, so switching spikes cannot end a phase early. Every gate change goes through a dead-time stage: switches that must open do so at once, and switches that must close wait a programmable number of cycles.

Top module: `chop_mixed_decay`

## Requirements
- R1: While reset is held, and from the first clock after `en` is sampled low, all four gate outputs are 0. While `en` stays low, the comparator inputs have no effect on the outputs.
- R2: A chopping period is PERIOD_TICKS sampled `osc_tick` pulses. The tick counter starts at 0 after reset, and a period boundary is the clock edge that samples the tick that completes the count. A bridge that is in Slow Decay, or parked and enabled, enters Charge on that edge. A parked bridge waits for the boundary even after `en` rises, including when `en` rises on the boundary edge itself.
- R3: Charge lasts until an accepted peak comparison, across as many period boundaries as needed.
- R4: `peak_hit` is ignored for BLANK_PEAK_CYC cycles after Charge begins. If it is already high, Fast Decay begins on the edge BLANK_PEAK_CYC+1 cycles after the Charge entry edge.
- R5: Fast Decay lasts until an accepted decay comparison, across period boundaries if needed.
- R6: `floor_hit` is ignored for BLANK_FLOOR_CYC cycles after Fast Decay begins. If it is already high, Slow Decay begins BLANK_FLOOR_CYC+1 cycles after the Fast Decay entry edge.
- R7: Slow Decay drives pattern 0101 and lasts until the next period boundary. If Slow Decay is entered on a boundary edge, that boundary is already used up, and the bridge stays in Slow Decay for a whole period.
- R8: On a gate change, the switches that open do so on the next clock. The switches that close follow DEAD_CYC cycles later. The high and low switch of one leg are never on together.
- R9: Gate vector {hi_a, lo_a, hi_b, lo_b}. With `polarity`=1, Charge is 1001 and Fast Decay is 0110. With `polarity`=0, Charge is 0110 and Fast Decay is 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable; low forces all gates off and parks the sequencer |
| polarity | input | 1 | Current direction; selects the diagonal pairs |
| osc_tick | input | 1 | One-cycle pulse per reference oscillator cycle |
| peak_hit | input | 1 | Winding current is at or above the peak threshold |
| floor_hit | input | 1 | Winding current is at or below the mixed-decay threshold |
| hi_a | output | 1 | High-side gate, leg A |
| lo_a | output | 1 | Low-side gate, leg A |
| hi_b | output | 1 | High-side gate, leg B |
| lo_b | output | 1 | Low-side gate, leg B |

## Verification
The case of interest is an accepted decay comparison that lands on the same edge as a period boundary. The bench holds `floor_hit` low until Fast Decay has crossed a boundary, then raises it on the negative edge that also carries the boundary tick. It passes only if the next Charge comes exactly one full period plus two cycles later. A second same-edge case raises `en` together with the boundary tick and expects the Charge drive two cycles later. In every phase, run lengths measured at the gate pins are compared with values computed from the blanking, dead-time and period parameters.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      PH_PARK   = 2'd0,
      PH_CHARGE = 2'd1,
      PH_FAST   = 2'd2,
      PH_SLOW   = 2'd3
   } phase_t;

   // Gate vector order: {hi_a, lo_a, hi_b, lo_b}
   function automatic logic [3:0] gate_pattern(phase_t ph, logic pol);
      case (ph)
         PH_CHARGE: return pol ? 4'b1001 : 4'b0110;
         PH_FAST:   return pol ? 4'b0110 : 4'b1001;
         PH_SLOW:   return 4'b0101;
         default:   return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/chop_period_div.sv
module chop_period_div #(
   parameter int PERIOD_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   output logic period_start
);
   localparam int TW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(PERIOD_TICKS - 1);
   localparam bit POW2 = ((PERIOD_TICKS & (PERIOD_TICKS - 1)) == 0);

   if (PERIOD_TICKS < 2) begin : g_bad_period
      $error("PERIOD_TICKS must be at least 2");
   end

   logic [TW-1:0] cnt;

   if (POW2) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (osc_tick) cnt <= cnt + 1'b1;
      end
   end else begin : g_compare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (osc_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign period_start = osc_tick && (cnt == LAST);

   // the counter only moves on a reference tick
   p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(cnt));
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> (cnt == '0));

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
   parameter int PEAK_CYC  = 125,
   parameter int FLOOR_CYC = 220
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_peak,
   input  logic arm_floor,
   output logic open
);
   localparam int LONGEST = (PEAK_CYC > FLOOR_CYC) ? PEAK_CYC : FLOOR_CYC;
   localparam int BW      = $clog2(LONGEST + 1);

   if (PEAK_CYC < 1 || FLOOR_CYC < 1) begin : g_bad_blank
      $error("blanking windows must be at least one cycle");
   end

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (arm_peak)      cnt <= BW'(PEAK_CYC);
      else if (arm_floor)     cnt <= BW'(FLOOR_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign open = (cnt == '0);

   p_peak_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arm_peak |=> !open);
   p_floor_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arm_floor |=> !open);

endmodule

// File: rtl/chop_dead_gen.sv
module chop_dead_gen #(
   parameter int DEAD_CYC = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] target,
   output logic [3:0] gate
);
   localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least one cycle");
   end

   logic [DW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate   <= '0;
         wait_q <= '0;
      end else if ((gate & ~target) != 4'b0000) begin
         gate   <= gate & target;
         wait_q <= DW'(DEAD_CYC - 1);
      end else if (gate != target && wait_q == '0) begin
         gate   <= target;
      end else if (wait_q != '0) begin
         wait_q <= wait_q - 1'b1;
      end
   end

   // per leg: bit 2*l+1 high side, bit 2*l low side
   for (genvar l = 0; l < 2; l++) begin : g_leg
      p_leg_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate[2*l+1] && gate[2*l]));
      p_high_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate[2*l+1]) |-> !$past(gate[2*l]));
      p_low_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate[2*l]) |-> !$past(gate[2*l+1]));
   end

endmodule

// File: rtl/chop_mixed_decay.sv
module chop_mixed_decay
   import chop_pkg::*;
#(
   parameter int PERIOD_TICKS    = 16,
   parameter int BLANK_PEAK_CYC  = 125,
   parameter int BLANK_FLOOR_CYC = 220,
   parameter int DEAD_CYC        = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic polarity,
   input  logic osc_tick,
   input  logic peak_hit,
   input  logic floor_hit,
   output logic hi_a,
   output logic lo_a,
   output logic hi_b,
   output logic lo_b
);
   phase_t     ph_q, ph_d;
   logic       period_start;
   logic       blank_open;
   logic       arm_peak, arm_floor;
   logic [3:0] target, gate;

   chop_period_div #(.PERIOD_TICKS(PERIOD_TICKS)) i_div (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .period_start(period_start));

   always_comb begin
      ph_d = ph_q;
      if (!en) begin
         ph_d = PH_PARK;
      end else begin
         unique case (ph_q)
            PH_PARK:   if (period_start)            ph_d = PH_CHARGE;
            PH_CHARGE: if (peak_hit && blank_open)  ph_d = PH_FAST;
            PH_FAST:   if (floor_hit && blank_open) ph_d = PH_SLOW;
            PH_SLOW:   if (period_start)            ph_d = PH_CHARGE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_PARK;
      else        ph_q <= ph_d;
   end

   assign arm_peak  = (ph_d == PH_CHARGE) && (ph_q != PH_CHARGE);
   assign arm_floor = (ph_d == PH_FAST)   && (ph_q != PH_FAST);

   chop_blank_timer #(.PEAK_CYC(BLANK_PEAK_CYC), .FLOOR_CYC(BLANK_FLOOR_CYC)) i_blank (
      .clk(clk), .rst_n(rst_n), .arm_peak(arm_peak), .arm_floor(arm_floor), .open(blank_open));

   assign target = en ? gate_pattern(ph_q, polarity) : 4'b0000;

   chop_dead_gen #(.DEAD_CYC(DEAD_CYC)) i_dead (
      .clk(clk), .rst_n(rst_n), .target(target), .gate(gate));

   assign {hi_a, lo_a, hi_b, lo_b} = gate;

   p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gate == 4'b0000));
   p_charge_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CHARGE && $past(ph_q) != PH_CHARGE) |-> $past(period_start));
   p_charge_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_q == PH_CHARGE && !peak_hit) |=> (ph_q == PH_CHARGE));
   p_peak_blanked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_q == PH_CHARGE && !blank_open) |=> (ph_q == PH_CHARGE));
   p_fast_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_q == PH_FAST && !floor_hit) |=> (ph_q == PH_FAST));
   p_floor_blanked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_q == PH_FAST && !blank_open) |=> (ph_q == PH_FAST));
   p_slow_to_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph_q == PH_SLOW && !period_start) |=> (ph_q == PH_SLOW));

endmodule

// File: tb/test_chop_mixed_decay.sv
module test_chop_mixed_decay;
   localparam int CLK_PERIOD = 10;
   localparam int PT   = 16;
   localparam int TDIV = 4;
   localparam int PCLK = PT * TDIV;
   localparam int BP   = 5;
   localparam int BF   = 8;
   localparam int DT   = 2;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, polarity = 1'b1;
   logic osc_tick = 1'b0, peak_hit = 1'b0, floor_hit = 1'b0;
   logic hi_a, lo_a, hi_b, lo_b;

   int checks = 0, failures = 0;
   int cyc = 0, boot = 0, drive_seen = 0;
   int run_len = 0;
   int last_run [16];
   int onset [16];
   int off_cnt [4];
   logic [3:0] cur = 4'b0000;
   logic [3:0] smp;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chop_mixed_decay #(.PERIOD_TICKS(PT), .BLANK_PEAK_CYC(BP),
                      .BLANK_FLOOR_CYC(BF), .DEAD_CYC(DT)) i_chop_mixed_decay (
      .clk(clk), .rst_n(rst_n), .en(en), .polarity(polarity), .osc_tick(osc_tick),
      .peak_hit(peak_hit), .floor_hit(floor_hit),
      .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b));

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // tick generation and gate monitor, both on the falling edge
   always @(negedge clk) begin
      boot++;
      if (rst_n) begin
         cyc++;
         osc_tick = (cyc % TDIV == 0);
         smp = {hi_a, lo_a, hi_b, lo_b};
         if (smp != 4'b0000) drive_seen++;
         if ((smp[3] && smp[2]) || (smp[1] && smp[0]))
            check(1'b0, "R8 leg overlap", int'(smp), 0);
         if (smp != cur) begin
            last_run[cur] = run_len;
            onset[smp] = cyc;
            for (int b = 0; b < 4; b++)
               if (smp[b] && !cur[b])
                  check(off_cnt[b^1] >= DT, "R8 dead time", off_cnt[b^1], DT);
            cur = smp;
            run_len = 1;
         end else begin
            run_len++;
         end
         for (int b = 0; b < 4; b++) off_cnt[b] = smp[b] ? 0 : off_cnt[b] + 1;
      end
      if (boot == 6) rst_n = 1'b1;
   end

   task automatic tick_to(int m);
      do begin @(negedge clk); #1; end while (cyc % PCLK != m);
   endtask

   task automatic wait_pat(logic [3:0] p);
      do begin @(negedge clk); #1; end while (cur != p);
   endtask

   initial begin : main
      int k, nset, nen, dseen;
      repeat (3) @(negedge clk);
      #1;
      check({hi_a, lo_a, hi_b, lo_b} == 4'b0000, "R1 reset", int'({hi_a, lo_a, hi_b, lo_b}), 0);
      while (!rst_n) @(negedge clk);

      // disabled: comparators toggle, nothing drives
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); #1;
         peak_hit = i[0]; floor_hit = i[1];
      end
      check(drive_seen == 0, "R1 disabled no drive", drive_seen, 0);

      // enable on the boundary edge itself, comparators already high
      peak_hit = 1'b1; floor_hit = 1'b1;
      tick_to(0);
      en = 1'b1; nen = cyc;
      wait_pat(4'b1001);
      check(onset[9] == nen + 2, "R2 start on boundary with enable", onset[9], nen + 2);
      tick_to(12);
      check(last_run[9] == BP + 1, "R4 blank from parked", last_run[9], BP + 1);
      tick_to(12);
      check(last_run[9] == BP + 1 - DT, "R4 charge blank", last_run[9], BP + 1 - DT);
      check(last_run[6] == BF + 1 - DT, "R6 fast blank", last_run[6], BF + 1 - DT);
      check(last_run[5] == PCLK - BP - BF - 2 - DT, "R7 slow length", last_run[5], PCLK - BP - BF - 2 - DT);
      check(last_run[0] == DT, "R8 gap charge to fast", last_run[0], DT);
      check(last_run[4] == DT, "R8 gap fast to slow", last_run[4], DT);
      check(last_run[1] == DT, "R8 gap slow to charge", last_run[1], DT);
      check(onset[1] % PCLK == 2, "R2 period boundary", onset[1] % PCLK, 2);

      // reversed polarity
      tick_to(40); polarity = 1'b0;
      tick_to(12); tick_to(12);
      check(last_run[6] == BP + 1 - DT, "R9 reversed charge pair", last_run[6], BP + 1 - DT);
      check(last_run[9] == BF + 1 - DT, "R9 reversed fast pair", last_run[9], BF + 1 - DT);
      check(last_run[5] == PCLK - BP - BF - 2 - DT, "R9 slow both low", last_run[5], PCLK - BP - BF - 2 - DT);
      check(onset[4] % PCLK == 2, "R9 reversed charge entry", onset[4] % PCLK, 2);
      tick_to(40); polarity = 1'b1;

      // long charge across boundaries
      tick_to(40); peak_hit = 1'b0;
      do begin @(negedge clk); #1; end while (!(cur == 4'b1001 && run_len == 100));
      k = run_len; peak_hit = 1'b1;
      wait_pat(4'b0000);
      check(last_run[9] == k + 1, "R3 charge across boundary", last_run[9], k + 1);
      wait_pat(4'b0101);
      check(last_run[6] == BF + 1 - DT, "R6 fast blank mid period", last_run[6], BF + 1 - DT);
      wait_pat(4'b0001);
      check(onset[1] % PCLK == 2, "R7 slow until boundary", onset[1] % PCLK, 2);

      // long fast decay, accepted on a boundary edge
      tick_to(40); floor_hit = 1'b0;
      do begin @(negedge clk); #1; end
         while (!(cur == 4'b0110 && run_len >= 100 && cyc % PCLK == 0));
      k = run_len; nset = cyc; floor_hit = 1'b1;
      wait_pat(4'b0100);
      check(last_run[6] == k + 1, "R5 fast across boundary", last_run[6], k + 1);
      wait_pat(4'b0001);
      check(onset[1] == nset + PCLK + 2, "R7 slow entered on boundary", onset[1], nset + PCLK + 2);

      // disable in the middle of fast decay
      tick_to(12);
      check(cur == 4'b0110, "R5 fast at probe point", int'(cur), 6);
      en = 1'b0;
      @(negedge clk); #1;
      check({hi_a, lo_a, hi_b, lo_b} == 4'b0000, "R1 off next cycle", int'({hi_a, lo_a, hi_b, lo_b}), 0);
      dseen = drive_seen;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk); #1;
         peak_hit = i[1]; floor_hit = i[0];
      end
      check(drive_seen == dseen, "R1 comparators ignored when disabled", drive_seen, dseen);

      // enable mid period: parked until the boundary
      tick_to(20);
      peak_hit = 1'b1; floor_hit = 1'b1;
      en = 1'b1; nen = cyc;
      wait_pat(4'b1001);
      check(onset[9] == nen - 20 + PCLK + 2, "R2 parked waits for boundary", onset[9], nen - 20 + PCLK + 2);
      check(drive_seen == dseen + 1, "R2 no early drive", drive_seen, dseen + 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule